// File: doc/BRIEF.md
# Power-Supply Supervisor Fault-Latch Sequencer

This block is the digital timing and latch core of a desktop power-supply supervisor. It takes comparator flags that are already digital: over-voltage on three rails (3.3 V, 5 V, 12 V), under-voltage on two rails (3.3 V, 5 V), and a flag for the power-good sense input being above its threshold. It also takes an active-low protection-enable input. From these it drives two open-drain outputs, a fault latch and a power-good signal. Each output is given as a pull-down enable plus the resolved logic level seen with an external pull-up.

Every duration counts ticks of one shared prescaler, and each duration is a parameter, so a test build can shorten them all. The durations are: the short detector glitch filter, the long debounce on the enable input, the under-voltage blanking window, the power-good delay and the extra latch-release delay. A qualified fault sets the latch, and power-good drops in the same cycle. The latch stays set until the enable input has been debounced high and the release delay has run out.

Top module: `psu_fault_seq`

## Requirements
- R1: While reset is asserted, and directly after it, faultLevel is 0 with faultPullDn 1, and pgoodLevel is 0 with pgoodPullDn 1. Reset clears every timer and filter and starts a blanking window. The debounced enable input comes out of reset in its high (protection off) state.
- R2: One tick is TICK_DIV clock cycles. A detector flag is acted on only after it has held a new value for GLITCH_TICKS ticks, and any change inside that time restarts the count. A pulse of at most (GLITCH_TICKS-1)*TICK_DIV cycles never reaches the latch.
- R3: With protection enabled (debounced pdonN low), a filtered over-voltage on any of the three ovFlag bits sets the latch, including inside the blanking window.
- R4: A filtered under-voltage on either uvFlag bit sets the latch only when no blanking window is running.
- R5: A set latch raises faultLevel and removes faultPullDn. pgoodLevel is 0 in every cycle in which faultLevel is 1.
- R6: The latch clears only after pdonN has been debounced high (DEBOUNCE_TICKS ticks of stable input) and RELEASE_TICKS further ticks have passed with it still high. A high pulse on pdonN shorter than the debounce leaves the latch set.
- R7: While debounced pdonN is high, no fault sets the latch.
- R8: A blanking window of BLANK_TICKS ticks restarts when the latch clears and when the filtered power-good input rises.
- R9: pgoodLevel rises PGOOD_TICKS ticks after the filtered power-good input rises, provided no fault is latched. If the filtered input falls, pgoodLevel falls in that same cycle and the delay starts again from zero. After the latch clears, pgoodLevel is 0 until the delay has run again.
- R10: Each open-drain output's level is always the complement of its pull-down enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that feeds the tick prescaler |
| rstN | input | 1 | Active-low power-on / low-supply reset, asynchronous |
| ovFlag | input | OV_RAILS | Over-voltage comparator flags, bit 0 = 3.3 V, bit 1 = 5 V, bit 2 = 12 V |
| uvFlag | input | UV_RAILS | Under-voltage comparator flags, bit 0 = 3.3 V, bit 1 = 5 V |
| pgiHigh | input | 1 | Power-good sense above threshold |
| pdonN | input | 1 | Protection enable, low = enabled, high = release the latch |
| faultPullDn | output | 1 | Pull-down enable of the fault-latch pin |
| faultLevel | output | 1 | Resolved fault-latch level, 1 = fault latched |
| pgoodPullDn | output | 1 | Pull-down enable of the power-good pin |
| pgoodLevel | output | 1 | Resolved power-good level |

## Verification
The bench applies every pulse width on one over-voltage rail from a single cycle up to the longest width that must be rejected, and shows that none of them sets the latch. Each of the five fault rails is then held long enough to set the latch. Every expected moment is computed as an earliest/latest window from the tick and filter counts, so the bench can tell a filter that is too short from one that is too long. Under-voltage raised inside a blanking window started by a power-good rise must wait for the window to end, while over-voltage in the same setup sets the latch at once. This separates the two fault paths. Short enable pulses, faults applied while protection is off, and a power-good drop followed by a second rise are used to check the release, disable and restart rules.

// File: rtl/psu_seq_pkg.sv
package psu_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic blankLoad;   // restart the under-voltage blanking window
    logic relRun;      // keep the latch release timer counting
    logic pgRun;       // keep the power-good delay timer counting
  } seqStrobe_t;

  // Qualified status from datapath to control
  typedef struct packed {
    logic ovAny;
    logic uvAny;
    logic pgiOk;
    logic pgiRise;
    logic pdonHigh;
    logic blanked;
    logic relDone;
    logic pgDone;
  } seqStatus_t;

endpackage

// File: rtl/psu_seq_filter.sv
// Two-flop synchroniser plus stability filter: the output takes the input
// value only after it has been stable for TICKS prescaler ticks.
module psu_seq_filter #(
  parameter int   TICKS = 8,
  parameter logic INIT  = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(TICKS + 1);

  logic syncA, syncB, syncC;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= INIT;
      syncB <= INIT;
      syncC <= INIT;
      dout  <= INIT;
      cnt   <= '0;
    end else begin
      syncA <= din;
      syncB <= syncA;
      syncC <= syncB;
      if (syncB != syncC || syncB == dout) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == CW'(TICKS - 1)) begin
          dout <= syncB;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psu_seq_timer.sv
// Tick timer: restart holds it at zero; otherwise it counts ticks up to
// TICKS and then reports done until restarted.
module psu_seq_timer #(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic restart,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == CW'(TICKS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (tick && !done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/psu_seq_datapath.sv
module psu_seq_datapath
  import psu_seq_pkg::*;
#(
  parameter int TICK_DIV       = 1000,
  parameter int GLITCH_TICKS   = 73,
  parameter int DEBOUNCE_TICKS = 38000,
  parameter int RELEASE_TICKS  = 2400,
  parameter int BLANK_TICKS    = 75000,
  parameter int PGOOD_TICKS    = 300000,
  parameter int OV_RAILS       = 3,
  parameter int UV_RAILS       = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [OV_RAILS-1:0] ovRaw,
  input  logic [UV_RAILS-1:0] uvRaw,
  input  logic                pgiRaw,
  input  logic                pdonRaw,
  input  seqStrobe_t          strobe,
  output seqStatus_t          status
);
  logic tick;

  // Shared timebase
  generate
    if (TICK_DIV > 1) begin : g_presc
      localparam int TW = $clog2(TICK_DIV);
      logic [TW-1:0] tickCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tickCnt <= '0;
        end else if (tickCnt == TW'(TICK_DIV - 1)) begin
          tickCnt <= '0;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
      assign tick = (tickCnt == TW'(TICK_DIV - 1));
    end else begin : g_nopresc
      assign tick = 1'b1;
    end
  endgenerate

  // Detector glitch filters
  logic [OV_RAILS-1:0] ovClean;
  logic [UV_RAILS-1:0] uvClean;
  logic pgiClean, pgiPrev, pdonClean;

  generate
    for (genvar i = 0; i < OV_RAILS; i++) begin : g_ov
      psu_seq_filter #(.TICKS(GLITCH_TICKS), .INIT(1'b0)) u_flt (
        .clk(clk), .rstN(rstN), .tick(tick), .din(ovRaw[i]), .dout(ovClean[i])
      );
    end
    for (genvar i = 0; i < UV_RAILS; i++) begin : g_uv
      psu_seq_filter #(.TICKS(GLITCH_TICKS), .INIT(1'b0)) u_flt (
        .clk(clk), .rstN(rstN), .tick(tick), .din(uvRaw[i]), .dout(uvClean[i])
      );
    end
  endgenerate

  psu_seq_filter #(.TICKS(GLITCH_TICKS), .INIT(1'b0)) u_pgiFlt (
    .clk(clk), .rstN(rstN), .tick(tick), .din(pgiRaw), .dout(pgiClean)
  );

  // Enable input comes out of reset in its high (protection off) state
  psu_seq_filter #(.TICKS(DEBOUNCE_TICKS), .INIT(1'b1)) u_pdonFlt (
    .clk(clk), .rstN(rstN), .tick(tick), .din(pdonRaw), .dout(pdonClean)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pgiPrev <= 1'b0;
    else       pgiPrev <= pgiClean;
  end

  // Timers
  logic blankDone, relDone, pgDone;

  psu_seq_timer #(.TICKS(BLANK_TICKS)) u_blank (
    .clk(clk), .rstN(rstN), .tick(tick), .restart(strobe.blankLoad), .done(blankDone)
  );
  psu_seq_timer #(.TICKS(RELEASE_TICKS)) u_release (
    .clk(clk), .rstN(rstN), .tick(tick), .restart(!strobe.relRun), .done(relDone)
  );
  psu_seq_timer #(.TICKS(PGOOD_TICKS)) u_pgood (
    .clk(clk), .rstN(rstN), .tick(tick), .restart(!strobe.pgRun), .done(pgDone)
  );

  always_comb begin
    status.ovAny    = |ovClean;
    status.uvAny    = |uvClean;
    status.pgiOk    = pgiClean;
    status.pgiRise  = pgiClean & ~pgiPrev;
    status.pdonHigh = pdonClean;
    status.blanked  = ~blankDone;
    status.relDone  = relDone;
    status.pgDone   = pgDone;
  end
endmodule

// File: rtl/psu_seq_ctrl.sv
module psu_seq_ctrl
  import psu_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       latched,
  output logic       pgoodOn
);
  logic setNow, clearNow;

  always_comb begin
    setNow   = !status.pdonHigh &&
               (status.ovAny || (status.uvAny && !status.blanked));
    clearNow = latched && status.relDone;

    strobe.relRun    = latched && status.pdonHigh;
    strobe.pgRun     = !latched && status.pgiOk;
    strobe.blankLoad = clearNow || status.pgiRise;

    pgoodOn = status.pgDone && status.pgiOk && !latched;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latched <= 1'b0;
    end else if (setNow) begin
      latched <= 1'b1;
    end else if (clearNow) begin
      latched <= 1'b0;
    end
  end
endmodule

// File: rtl/psu_fault_seq.sv
module psu_fault_seq
  import psu_seq_pkg::*;
#(
  parameter int TICK_DIV       = 1000,
  parameter int GLITCH_TICKS   = 73,
  parameter int DEBOUNCE_TICKS = 38000,
  parameter int RELEASE_TICKS  = 2400,
  parameter int BLANK_TICKS    = 75000,
  parameter int PGOOD_TICKS    = 300000,
  parameter int OV_RAILS       = 3,
  parameter int UV_RAILS       = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [OV_RAILS-1:0] ovFlag,
  input  logic [UV_RAILS-1:0] uvFlag,
  input  logic                pgiHigh,
  input  logic                pdonN,
  output logic                faultPullDn,
  output logic                faultLevel,
  output logic                pgoodPullDn,
  output logic                pgoodLevel
);
  seqStrobe_t strobe;
  seqStatus_t status;
  logic latched, pgoodOn;

  psu_seq_datapath #(
    .TICK_DIV(TICK_DIV), .GLITCH_TICKS(GLITCH_TICKS),
    .DEBOUNCE_TICKS(DEBOUNCE_TICKS), .RELEASE_TICKS(RELEASE_TICKS),
    .BLANK_TICKS(BLANK_TICKS), .PGOOD_TICKS(PGOOD_TICKS),
    .OV_RAILS(OV_RAILS), .UV_RAILS(UV_RAILS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ovRaw(ovFlag), .uvRaw(uvFlag),
    .pgiRaw(pgiHigh), .pdonRaw(pdonN), .strobe(strobe), .status(status)
  );

  psu_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .status(status), .strobe(strobe),
    .latched(latched), .pgoodOn(pgoodOn)
  );

  // Open-drain: latched fault releases the pull-down; power-good likewise
  assign faultPullDn = ~latched;
  assign faultLevel  = latched;
  assign pgoodPullDn = ~pgoodOn;
  assign pgoodLevel  = pgoodOn;
endmodule

// File: rtl/psu_fault_seq_chk.sv
module psu_fault_seq_chk #(
  parameter int TICK_DIV       = 1000,
  parameter int DEBOUNCE_TICKS = 38000
) (
  input logic clk,
  input logic rstN,
  input logic pdonN,
  input logic faultPullDn,
  input logic faultLevel,
  input logic pgoodPullDn,
  input logic pgoodLevel
);
  localparam int HI_LIMIT = DEBOUNCE_TICKS * TICK_DIV + 6;

  int pdonHiRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pdonHiRun <= 0;
    else if (!pdonN)           pdonHiRun <= 0;
    else if (pdonHiRun < HI_LIMIT) pdonHiRun <= pdonHiRun + 1;
  end

  // R1: reset state of both outputs
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_state: assert (faultPullDn && !faultLevel && pgoodPullDn && !pgoodLevel)
        else $error("reset state violated");
    end
  end

  // R5: power-good never high while a fault is latched
  a_r5_fault_blocks_pgood: assert property (@(posedge clk) disable iff (!rstN)
    faultLevel |-> !pgoodLevel);

  // R9: power-good stays low in the cycle the latch clears
  a_r9_pgood_after_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultLevel) |-> !pgoodLevel);

  // R7: after a long stable high on the enable input, the latch cannot set
  a_r7_disabled_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (pdonHiRun >= HI_LIMIT) |-> !$rose(faultLevel));

  // R6: a latched fault stays latched while the enable input is low
  a_r6_hold_while_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (faultLevel && !pdonN && $past(!pdonN) && $past(faultLevel)) |=> faultLevel || $past(pdonN));
endmodule

bind psu_fault_seq psu_fault_seq_chk #(
  .TICK_DIV(TICK_DIV), .DEBOUNCE_TICKS(DEBOUNCE_TICKS)
) u_chk (
  .clk(clk), .rstN(rstN), .pdonN(pdonN),
  .faultPullDn(faultPullDn), .faultLevel(faultLevel),
  .pgoodPullDn(pgoodPullDn), .pgoodLevel(pgoodLevel)
);

// File: tb/sim_psu_fault_seq.sv
`timescale 1ns/1ps
module sim_psu_fault_seq;
  localparam int DIV = 4;
  localparam int GL  = 3;
  localparam int DB  = 5;
  localparam int REL = 2;
  localparam int BL  = 6;
  localparam int PG  = 8;

  // Earliest / latest edge (after the drive point) at which a filter output moves
  localparam int GL_LO = 4 + (GL - 1) * DIV;
  localparam int GL_HI = 3 + GL * DIV;
  localparam int DB_LO = 4 + (DB - 1) * DIV;
  localparam int DB_HI = 3 + DB * DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] ovFlag = '0;
  logic [1:0] uvFlag = '0;
  logic pgiHigh = 1'b0;
  logic pdonN = 1'b1;
  logic faultPullDn, faultLevel, pgoodPullDn, pgoodLevel;

  int checks = 0;
  int fails = 0;
  int edgeCnt = 0;
  int mark = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) edgeCnt++;

  psu_fault_seq #(
    .TICK_DIV(DIV), .GLITCH_TICKS(GL), .DEBOUNCE_TICKS(DB),
    .RELEASE_TICKS(REL), .BLANK_TICKS(BL), .PGOOD_TICKS(PG)
  ) u0 (
    .clk(clk), .rstN(rstN), .ovFlag(ovFlag), .uvFlag(uvFlag),
    .pgiHigh(pgiHigh), .pdonN(pdonN), .faultPullDn(faultPullDn),
    .faultLevel(faultLevel), .pgoodPullDn(pgoodPullDn), .pgoodLevel(pgoodLevel)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Checks both outputs, and the open-drain relation of each (R10)
  task automatic expectOut(input bit expFault, input bit expPg, input string req);
    check(faultLevel == expFault, req, "faultLevel", int'(faultLevel), int'(expFault));
    check(pgoodLevel == expPg, req, "pgoodLevel", int'(pgoodLevel), int'(expPg));
    check(faultPullDn == !faultLevel && pgoodPullDn == !pgoodLevel, "R10",
          "pull-down vs level", int'({faultPullDn, pgoodPullDn}),
          int'({!faultLevel, !pgoodLevel}));
  endtask

  task automatic driveMark();
    @(posedge clk); #1;
    mark = edgeCnt;
  endtask

  task automatic toEdge(input int n);
    while (edgeCnt < mark + n) begin
      @(posedge clk); #1;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic releaseLatch();
    driveMark(); pdonN = 1'b1;
    toEdge(DB_HI + REL * DIV + 2);
    driveMark(); pdonN = 1'b0;
    toEdge(DB_HI + 4);
    idle(BL * DIV + 6);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    expectOut(1'b0, 1'b0, "R1");
    @(posedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    expectOut(1'b0, 1'b0, "R1");

    // R7: faults ignored while enable input is high since reset
    driveMark(); ovFlag[0] = 1'b1;
    toEdge(GL_HI + 20);
    expectOut(1'b0, 1'b0, "R7");
    ovFlag[0] = 1'b0;
    idle(GL_HI + 4);

    driveMark(); pdonN = 1'b0;
    toEdge(DB_HI + 4);
    idle(BL * DIV + 6);

    // R2: sweep of short pulses on one rail, none may set the latch
    for (int w = 1; w <= (GL - 1) * DIV; w++) begin
      driveMark(); ovFlag[0] = 1'b1;
      idle(w - 1);
      ovFlag[0] = 1'b0;
      idle(GL_HI + 4);
      @(negedge clk);
      check(faultLevel == 1'b0, "R2", $sformatf("pulse width %0d", w), int'(faultLevel), 0);
    end

    // R3/R4/R5/R6: each rail sets the latch in its window and is released
    for (int r = 0; r < 5; r++) begin
      driveMark();
      if (r < 3) ovFlag[r] = 1'b1; else uvFlag[r-3] = 1'b1;
      toEdge(GL_LO - 1);
      expectOut(1'b0, 1'b0, "R2");
      toEdge(GL_HI + 2);
      expectOut(1'b1, 1'b0, (r < 3) ? "R3" : "R4");
      check(faultPullDn == 1'b0, "R5", "pull-down released", int'(faultPullDn), 0);
      ovFlag = '0; uvFlag = '0;
      idle(GL_HI + 4);
      driveMark(); pdonN = 1'b1;
      toEdge(DB_LO + 1 + (REL - 1) * DIV);
      expectOut(1'b1, 1'b0, "R6");
      toEdge(DB_HI + REL * DIV + 2);
      expectOut(1'b0, 1'b0, "R6");
      driveMark(); pdonN = 1'b0;
      toEdge(DB_HI + 4);
      idle(BL * DIV + 6);
    end

    // R6: a short high on the enable input does not release the latch
    driveMark(); ovFlag[1] = 1'b1;
    toEdge(GL_HI + 2);
    ovFlag[1] = 1'b0;
    idle(GL_HI + 4);
    pdonN = 1'b1;
    idle((DB - 1) * DIV - 1);
    pdonN = 1'b0;
    idle(DB_HI + REL * DIV + 10);
    @(negedge clk);
    check(faultLevel == 1'b1, "R6", "short enable pulse", int'(faultLevel), 1);
    releaseLatch();

    // R8/R4: power-good rise restarts blanking, under-voltage waits for it
    driveMark(); pgiHigh = 1'b1;
    idle(7);
    uvFlag[0] = 1'b1;
    toEdge(GL_LO + 2 + (BL - 1) * DIV);
    check(faultLevel == 1'b0, "R8", "UV blanked after PGI rise", int'(faultLevel), 0);
    toEdge(GL_HI + BL * DIV + 3);
    check(faultLevel == 1'b1, "R4", "UV after blanking", int'(faultLevel), 1);
    uvFlag = '0; pgiHigh = 1'b0;
    idle(GL_HI + 4);
    releaseLatch();

    // R3: over-voltage is not blanked
    driveMark(); pgiHigh = 1'b1;
    idle(7);
    ovFlag[2] = 1'b1;
    toEdge(GL_HI + 10);
    check(faultLevel == 1'b1, "R3", "OV inside blanking", int'(faultLevel), 1);
    ovFlag = '0; pgiHigh = 1'b0;
    idle(GL_HI + 4);
    releaseLatch();

    // R9: power-good delay, drop, restart from zero (two rises)
    for (int k = 0; k < 2; k++) begin
      driveMark(); pgiHigh = 1'b1;
      toEdge(GL_LO + (PG - 1) * DIV);
      expectOut(1'b0, 1'b0, "R9");
      toEdge(GL_HI + PG * DIV + 1);
      expectOut(1'b0, 1'b1, "R9");
      if (k == 0) begin
        driveMark(); pgiHigh = 1'b0;
        toEdge(GL_LO - 1);
        expectOut(1'b0, 1'b1, "R9");
        toEdge(GL_HI + 1);
        expectOut(1'b0, 1'b0, "R9");
        idle(3 * DIV);
      end
    end

    // R5: a fault drops power-good in the same cycle
    driveMark(); ovFlag[0] = 1'b1;
    for (int c = 0; c < GL_HI + 6; c++) begin
      @(negedge clk);
      if (faultLevel) break;
      check(pgoodLevel == 1'b1, "R5", "pgood before fault", int'(pgoodLevel), 1);
    end
    check(faultLevel == 1'b1 && pgoodLevel == 1'b0, "R5", "pgood at fault",
          int'({faultLevel, pgoodLevel}), 2);
    ovFlag = '0;
    idle(GL_HI + 4);

    // R9: after release, power-good waits the full delay again
    driveMark(); pdonN = 1'b1;
    for (int c = 0; c < DB_HI + REL * DIV + 4; c++) begin
      @(negedge clk);
      if (!faultLevel) break;
    end
    check(faultLevel == 1'b0 && pgoodLevel == 1'b0, "R9", "pgood at release",
          int'({faultLevel, pgoodLevel}), 0);
    idle((PG - 1) * DIV - 2);
    @(negedge clk);
    check(pgoodLevel == 1'b0, "R9", "pgood delay after release", int'(pgoodLevel), 0);
    idle(2 * DIV + 4);
    @(negedge clk);
    check(pgoodLevel == 1'b1, "R9", "pgood after release delay", int'(pgoodLevel), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule